// File: doc/BRIEF.md
# Control Register Write Handler

This block owns three processor control registers: a mode register, a page-table base register and a feature register. Software writes reach it as a strobe, a register select and a data word. For each write it works out the stored value and updates a small set of hidden mode flags. When the write changes a field that affects address translation, it raises a one-cycle request to flush the translation cache.

The block also handles the 64-bit long-mode transition. Turning paging on while the extended-feature long-mode enable is set enters long mode. This entry is refused unless physical-address extension is on. Turning paging off while in long mode leaves it and asks the fetch unit to cut the instruction pointer to 32 bits. A separate address-line-20 gate input is tracked as an address mask, and every change of the gate also flushes the translation cache.

Top module: `ctlreg_unit`

## Requirements
- R1: A mode-register write (select 0) pulses `flush` only when bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) differs from the stored value. A write that changes only other bits stores them without a flush.
- R2: A mode write that sets bit 31 while stored bit 31 is clear and `lme` is high is accepted only if feature bit 5 (PAE) is set, and it then sets `lma`. With PAE clear the write is dropped entirely: nothing is stored, there is no flush and `lma` stays low.
- R3: Bit 4 of `mode_q` always reads 1, both after reset and after any write.
- R4: A mode write that clears bit 31 while `lma` is high clears `lma` and raises `ip_trunc` for exactly one cycle, in the cycle after the write.
- R5: `hflags` is laid out as follows. Bit 0 copies mode bit 0. Bit 1 (address-add-segment) is 1 whenever mode bit 0 is 0. Bits 2 to 4 copy mode bits 1 to 3. Bit 5 copies feature bit 9. Bit 6 copies feature bit 21.
- R6: A base-register write (select 1) stores all `ADDR_W` bits and pulses `flush` only while stored mode bit 31 is set.
- R7: A feature-register write (select 2) pulses `flush` when any of feature bits 4, 5, 7, 12, 20 or 21 changes, and at no other time.
- R8: Before a feature write is stored, bit 9 is cleared when `cap_fxsave` is low, bit 21 is cleared when `cap_sap` is low, and bit 22 is cleared when `cap_pkey` is low.
- R9: A change on `a20_gate` pulses `flush` in the next cycle and sets `a20_mask` bit 20 to the gate value. Every other mask bit is always 1.
- R10: After reset: `mode_q` is 0x10, `base_q` and `feat_q` are 0, `lma`, `flush` and `ip_trunc` are low, and `a20_mask` bit 20 is 0. `flush` is registered: it appears in the cycle after its cause and lasts one cycle.
- R11: A write with select 3 changes no register and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 base, 2 feature, 3 none |
| wr_data | input | ADDR_W | Write data; the mode and feature registers use the low 32 bits |
| lme | input | 1 | Long-mode enable from the extended-feature register |
| cap_fxsave | input | 1 | Capability: extended FP save allowed |
| cap_sap | input | 1 | Capability: supervisor access protection |
| cap_pkey | input | 1 | Capability: protection keys |
| a20_gate | input | 1 | Address-line-20 gate level |
| mode_q | output | 32 | Stored mode register |
| base_q | output | ADDR_W | Stored page-table base |
| feat_q | output | 32 | Stored feature register |
| hflags | output | 7 | Hidden mode flags (see R5) |
| lma | output | 1 | Long mode active |
| flush | output | 1 | One-cycle translation-cache flush request |
| ip_trunc | output | 1 | One-cycle request to truncate the instruction pointer to 32 bits and leave 64-bit code mode |
| a20_mask | output | ADDR_W | Address mask with bit 20 following the gate |

## Verification
The bench goes after the long-mode corners. A paging-on write with PAE clear must leave the mode register unchanged. A design that stored it anyway, or flushed, would show a changed `mode_q` or a pulse on `flush`. A paging-off write while in long mode must raise exactly one `ip_trunc`, while the same write outside long mode must not. The bench also writes values that differ only in bits outside the flush sets, checking that no spurious flush appears. It checks that capability-gated feature bits read back as 0. It checks that a base write with paging off stays silent. Finally, it toggles the address gate and inspects the whole mask.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int MB_PE = 0;
   localparam int MB_MP = 1;
   localparam int MB_EM = 2;
   localparam int MB_TS = 3;
   localparam int MB_ET = 4;
   localparam int MB_WP = 16;
   localparam int MB_PG = 31;

   localparam int FB_PSE  = 4;
   localparam int FB_PAE  = 5;
   localparam int FB_PGE  = 7;
   localparam int FB_FXS  = 9;
   localparam int FB_LA57 = 12;
   localparam int FB_SMEP = 20;
   localparam int FB_SMAP = 21;
   localparam int FB_PKEY = 22;

   localparam int A20_BIT = 20;

   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_BASE = 2'd1,
      SEL_FEAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam logic [31:0] MODE_FLUSH_MASK =
      (32'h1 << MB_PG) | (32'h1 << MB_WP) | (32'h1 << MB_PE);
   localparam logic [31:0] FEAT_FLUSH_MASK =
      (32'h1 << FB_PSE) | (32'h1 << FB_PAE) | (32'h1 << FB_PGE) |
      (32'h1 << FB_LA57) | (32'h1 << FB_SMEP) | (32'h1 << FB_SMAP);
   localparam logic [31:0] MODE_RESET = 32'h1 << MB_ET;
endpackage

// File: rtl/ctl_mode_path.sv
module ctl_mode_path
   import ctlreg_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic [REG_W-1:0] cur_mode,
   input  logic             cur_lma,
   input  logic             lme,
   input  logic             pae,
   input  logic [REG_W-1:0] new_data,
   output logic [REG_W-1:0] nxt_mode,
   output logic             nxt_lma,
   output logic             accept,
   output logic             flush_req,
   output logic             trunc_req
);
   logic entering, leaving;

   always_comb begin
      entering  = !cur_mode[MB_PG] && new_data[MB_PG] && lme;
      leaving   = cur_mode[MB_PG] && !new_data[MB_PG] && cur_lma;
      accept    = !(entering && !pae);
      nxt_mode  = new_data | REG_W'(MODE_RESET);
      nxt_lma   = entering ? 1'b1 : (leaving ? 1'b0 : cur_lma);
      flush_req = accept && (((new_data ^ cur_mode) & REG_W'(MODE_FLUSH_MASK)) != '0);
      trunc_req = leaving;
   end
endmodule

// File: rtl/ctl_feat_path.sv
module ctl_feat_path
   import ctlreg_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic [REG_W-1:0] cur_feat,
   input  logic [REG_W-1:0] new_data,
   input  logic             cap_fxsave,
   input  logic             cap_sap,
   input  logic             cap_pkey,
   output logic [REG_W-1:0] nxt_feat,
   output logic             flush_req
);
   localparam int NCAP = 3;
   localparam int CAP_BIT [NCAP] = '{FB_FXS, FB_SMAP, FB_PKEY};

   logic [NCAP-1:0]  cap_vec;
   logic [REG_W-1:0] strip;

   assign cap_vec = {cap_pkey, cap_sap, cap_fxsave};

   for (genvar g = 0; g < NCAP; g++) begin : g_cap
      logic [REG_W-1:0] one;
      assign one = cap_vec[g] ? '0 : (REG_W'(1) << CAP_BIT[g]);
   end

   always_comb begin
      strip = g_cap[0].one | g_cap[1].one | g_cap[2].one;
      nxt_feat  = new_data & ~strip;
      flush_req = ((nxt_feat ^ cur_feat) & REG_W'(FEAT_FLUSH_MASK)) != '0;
   end
endmodule

// File: rtl/ctl_a20_gate.sv
module ctl_a20_gate
   import ctlreg_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate,
   output logic [ADDR_W-1:0] mask,
   output logic              flush_req
);
   logic state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= 1'b0;
      else        state_q <= gate;
   end

   assign flush_req = rst_n && (gate != state_q);

   for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      if (b == A20_BIT) begin : g_gate
         assign mask[b] = state_q;
      end else begin : g_one
         assign mask[b] = 1'b1;
      end
   end
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
   import ctlreg_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              lme,
   input  logic              cap_fxsave,
   input  logic              cap_sap,
   input  logic              cap_pkey,
   input  logic              a20_gate,
   output logic [31:0]       mode_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [31:0]       feat_q,
   output logic [6:0]        hflags,
   output logic              lma,
   output logic              flush,
   output logic              ip_trunc,
   output logic [ADDR_W-1:0] a20_mask
);
   if (REG_W != 32) begin : g_bad_reg
      $error("ctlreg_unit: REG_W must be 32");
   end
   if (ADDR_W < REG_W) begin : g_bad_addr
      $error("ctlreg_unit: ADDR_W must be at least REG_W");
   end

   logic [REG_W-1:0] m_nxt, f_nxt;
   logic             m_lma, m_acc, m_flush, m_trunc, f_flush, a_flush;
   logic             wr_mode, wr_base, wr_feat;

   assign wr_mode = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
   assign wr_base = wr_en && (reg_sel_e'(wr_sel) == SEL_BASE);
   assign wr_feat = wr_en && (reg_sel_e'(wr_sel) == SEL_FEAT);

   ctl_mode_path #(.REG_W(REG_W)) u_mode (
      .cur_mode (mode_q),
      .cur_lma  (lma),
      .lme      (lme),
      .pae      (feat_q[FB_PAE]),
      .new_data (wr_data[REG_W-1:0]),
      .nxt_mode (m_nxt),
      .nxt_lma  (m_lma),
      .accept   (m_acc),
      .flush_req(m_flush),
      .trunc_req(m_trunc)
   );

   ctl_feat_path #(.REG_W(REG_W)) u_feat (
      .cur_feat  (feat_q),
      .new_data  (wr_data[REG_W-1:0]),
      .cap_fxsave(cap_fxsave),
      .cap_sap   (cap_sap),
      .cap_pkey  (cap_pkey),
      .nxt_feat  (f_nxt),
      .flush_req (f_flush)
   );

   ctl_a20_gate #(.ADDR_W(ADDR_W)) u_a20 (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (a20_gate),
      .mask     (a20_mask),
      .flush_req(a_flush)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_RESET;
         base_q   <= '0;
         feat_q   <= '0;
         lma      <= 1'b0;
         flush    <= 1'b0;
         ip_trunc <= 1'b0;
      end else begin
         flush    <= a_flush
                     || (wr_mode && m_flush)
                     || (wr_base && mode_q[MB_PG])
                     || (wr_feat && f_flush);
         ip_trunc <= wr_mode && m_acc && m_trunc;
         if (wr_mode && m_acc) begin
            mode_q <= m_nxt;
            lma    <= m_lma;
         end
         if (wr_base) base_q <= wr_data;
         if (wr_feat) feat_q <= f_nxt;
      end
   end

   always_comb begin
      hflags[0] = mode_q[MB_PE];
      hflags[1] = !mode_q[MB_PE];
      hflags[2] = mode_q[MB_MP];
      hflags[3] = mode_q[MB_EM];
      hflags[4] = mode_q[MB_TS];
      hflags[5] = feat_q[FB_FXS];
      hflags[6] = feat_q[FB_SMAP];
   end
endmodule

// File: rtl/ctlreg_unit_chk.sv
module ctlreg_unit_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic              cap_pkey,
   input logic              a20_gate,
   input logic [31:0]       mode_q,
   input logic [31:0]       feat_q,
   input logic [6:0]        hflags,
   input logic              lma,
   input logic              flush,
   input logic              ip_trunc,
   input logic [ADDR_W-1:0] a20_mask
);
   p_lma_needs_pae_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lma) |-> (feat_q[5] && mode_q[31]));

   p_ext_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[4]);

   p_trunc_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ip_trunc |-> (!lma && $past(lma)));

   p_addseg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hflags[0] |-> hflags[1]);

   p_base_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && !mode_q[31] && a20_gate == a20_mask[20])
      |=> !flush);

   p_pkey_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !cap_pkey) |=> !feat_q[22]);

   p_mask_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&a20_mask[ADDR_W-1:21]) && (&a20_mask[19:0]));

   p_sel_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && a20_gate == a20_mask[20])
      |=> ($stable(mode_q) && $stable(feat_q) && !flush));
endmodule

bind ctlreg_unit ctlreg_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .cap_pkey(cap_pkey), .a20_gate(a20_gate), .mode_q(mode_q),
   .feat_q(feat_q), .hflags(hflags), .lma(lma), .flush(flush),
   .ip_trunc(ip_trunc), .a20_mask(a20_mask)
);

// File: tb/ctlreg_unit_tb.sv
`timescale 1ns/1ps
module ctlreg_unit_tb;
   localparam int ADDR_W = 64;
   localparam int NVEC   = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_sel = 2'd0;
   logic [ADDR_W-1:0] wr_data = '0;
   logic              lme = 1'b0;
   logic              cap_fxsave = 1'b1, cap_sap = 1'b1, cap_pkey = 1'b1;
   logic              a20_gate = 1'b0;
   logic [31:0]       mode_q, feat_q;
   logic [ADDR_W-1:0] base_q, a20_mask;
   logic [6:0]        hflags;
   logic              lma, flush, ip_trunc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctlreg_unit #(.ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .lme(lme), .cap_fxsave(cap_fxsave),
      .cap_sap(cap_sap), .cap_pkey(cap_pkey), .a20_gate(a20_gate),
      .mode_q(mode_q), .base_q(base_q), .feat_q(feat_q), .hflags(hflags),
      .lma(lma), .flush(flush), .ip_trunc(ip_trunc), .a20_mask(a20_mask)
   );

   // {sel, data, expected flush}; lme low, all capabilities present
   localparam logic [66:0] VEC [NVEC] = '{
      {2'd0, 64'h0000_0001, 1'b1},   // R1 PE set
      {2'd0, 64'h0000_0003, 1'b0},   // R1 MP only
      {2'd0, 64'h0001_0003, 1'b1},   // R1 WP set
      {2'd1, 64'h1234, 1'b0},        // R6 paging off
      {2'd2, 64'h0000_0008, 1'b0},   // R7 bit 3 not listed
      {2'd2, 64'h0000_0080, 1'b1},   // R7 PGE
      {2'd0, 64'h8001_0003, 1'b1},   // R1 PG set
      {2'd1, 64'h5678, 1'b1},        // R6 paging on
      {2'd3, 64'hFFFF_FFFF, 1'b0},   // R11 no register
      {2'd2, 64'h0000_0088, 1'b0}    // R7 only bit 3 changes
   };

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 mode", mode_q, 64'h10);
      chk("R3 et after reset", mode_q[4], 1);
      chk("R10 base", base_q, 0);
      chk("R10 feat", feat_q, 0);
      chk("R10 lma/flush/trunc", {lma, flush, ip_trunc}, 0);
      chk("R10 mask", a20_mask, ~(64'h1 << 20));
      chk("R5 addseg at reset", hflags[1:0], 2'b10);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][66:65], VEC[i][64:1]);
         chk($sformatf("R1/R6/R7/R11 vec %0d flush", i), flush, VEC[i][0]);
      end
      @(negedge clk);
      chk("R10 flush one cycle", flush, 0);
      chk("R3 mode stored", mode_q, 64'h8001_0013);
      chk("R6 base stored", base_q, 64'h5678);
      chk("R11 feat untouched", feat_q, 64'h88);
      chk("R5 flags", hflags, 7'b0000101);

      // R2/R4: long mode sequencing
      lme = 1'b1;
      wr(2'd0, 64'h0001_0003);
      chk("R4 no trunc outside long mode", {ip_trunc, lma, flush}, 3'b001);
      wr(2'd0, 64'h8001_0003);
      chk("R2 refused without PAE mode", mode_q, 64'h0001_0013);
      chk("R2 refused no flush/lma", {flush, lma}, 0);
      wr(2'd2, 64'h0000_00A8);
      chk("R7 PAE flush", flush, 1);
      wr(2'd0, 64'h8001_0003);
      chk("R2 enter", {lma, flush, ip_trunc}, 3'b110);
      wr(2'd0, 64'h0001_000B);
      chk("R4 leave", {lma, ip_trunc, flush}, 3'b011);
      chk("R5 ts copy", hflags[4:0], 5'b10101);
      @(negedge clk);
      chk("R4 trunc one cycle", ip_trunc, 0);
      lme = 1'b0;

      // R8 capability gating
      cap_fxsave = 1'b0; cap_sap = 1'b0; cap_pkey = 1'b0;
      wr(2'd2, 64'h0070_0220);
      chk("R8 gated store", feat_q, 64'h0010_0020);
      chk("R5 fxs/sap flags", hflags[6:5], 0);
      cap_fxsave = 1'b1; cap_sap = 1'b1; cap_pkey = 1'b1;
      wr(2'd2, 64'h0070_0220);
      chk("R8 allowed store", feat_q, 64'h0070_0220);
      chk("R5 fxs/sap set", hflags[6:5], 2'b11);
      chk("R7 SMAP flush", flush, 1);

      // R5 protection off
      wr(2'd0, 64'h0);
      chk("R5 pe off addseg", hflags[1:0], 2'b10);

      // R9 address gate
      @(negedge clk);
      a20_gate = 1'b1;
      @(negedge clk);
      chk("R9 flush on rise", flush, 1);
      chk("R9 mask open", a20_mask, ~64'h0);
      @(negedge clk);
      chk("R9 single flush", flush, 0);
      a20_gate = 1'b0;
      @(negedge clk);
      chk("R9 flush on fall", flush, 1);
      chk("R9 mask closed", a20_mask, ~(64'h1 << 20));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule